// File: doc/BRIEF.md
# Shared Timer Interrupt Request Latch

This block gathers compare-match event pulses from three timer channels and turns them into one interrupt request line toward the processor. Each channel owns a single pending flag. An event raises that flag only while the channel's interrupt enable input is high. Once raised, the flag stays up until the processor acknowledges that channel. Clearing the enable does not lower it, and further events do not stack on top of it.

When the processor pulses the acknowledge strobe, a fixed-priority selector chooses the lowest-numbered pending channel. The block latches that channel's index onto the vector output and clears only that channel's flag. The other flags remain pending, so the shared line stays high until every channel has been serviced. An event from the channel being acknowledged in the same cycle wins over the clear, so that channel stays pending.

Top module: `tirq_latch`

## Requirements
- R1: `irq_o` is high exactly when at least one channel is pending. A qualifying event sampled at a rising clock edge makes `irq_o` high from that edge on.
- R2: When several channels are pending, an acknowledge selects channel 0 over channel 1 and channel 1 over channel 2.
- R3: An event pulse on channel n while `ien_i[n]` is low does not make channel n pending.
- R4: Lowering `ien_i[n]` while channel n is pending leaves it pending, and `irq_o` stays high.
- R5: Several events on one channel before its acknowledge leave one pending request. A single acknowledge of that channel removes it, and `irq_o` falls if no other channel is pending.
- R6: On an acknowledge edge with any channel pending, `vec_o` takes the selected channel's number in binary (0, 1 or 2). It holds that value until the next such acknowledge.
- R7: An acknowledge clears only the selected channel's pending flag.
- R8: If a qualifying event on the selected channel arrives in the same cycle as the acknowledge, that channel stays pending.
- R9: An acknowledge while no channel is pending changes neither `vec_o` nor any pending flag.
- R10: While `rst_n` is low, `irq_o` is 0 and `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 3 | Per-channel compare-match event, one bit per channel, sampled each edge |
| ien_i | input | 3 | Per-channel interrupt enable |
| ack_i | input | 1 | Acknowledge strobe from the processor, one cycle |
| irq_o | output | 1 | Shared interrupt request |
| vec_o | output | 2 | Index of the channel selected by the last effective acknowledge |

## Verification
A flag that is wrongly set or cleared appears on `irq_o` in the cycle after the edge that caused it. A flag that was lost can also appear one acknowledge later, when `vec_o` points at a lower-priority channel than expected. A selector with the wrong order, or a clear aimed at the wrong channel, needs a drain sequence to expose it. The bench loads several channels and acknowledges them one by one, comparing `vec_o` and `irq_o` after each edge. A set-versus-clear collision that resolves the wrong way shows only as `irq_o` falling one cycle after the colliding acknowledge.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

  localparam int TIRQ_CH_DEFAULT = 3;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tirq_pend_cell.sv
module tirq_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic en_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_q;
  logic pend_d;
  logic set_w;
  logic upd_w;

  // Set wins over clear in a collision cycle.
  always_comb begin
    set_w  = evt_i & en_i;
    upd_w  = set_w | clr_i;
    pend_d = set_w | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (upd_w) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  p_no_set_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !(evt_i && en_i)) |=> !pend_q);

  p_hold_without_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i) |=> pend_q);

  p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && en_i) |=> pend_q);

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(evt_i && en_i)) |=> !pend_q);

endmodule

// File: rtl/tirq_prio_sel.sv
module tirq_prio_sel #(
  parameter int NUM_CH = 3,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_CH-1:0] pend_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [NUM_CH-1:0] grant_o
);

  // Walk from the highest channel down so the lowest pending one is kept last.
  always_comb begin
    idx_o   = '0;
    grant_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        idx_o   = IDX_W'(i);
        grant_o = '0;
        grant_o[i] = 1'b1;
      end
    end
    any_o = |pend_i;
  end

endmodule

// File: rtl/tirq_vec_reg.sv
module tirq_vec_reg #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] vec_o
);

  logic [IDX_W-1:0] vec_q;
  logic [IDX_W-1:0] vec_d;

  always_comb begin
    vec_d = load_i ? idx_i : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (load_i) begin
      vec_q <= vec_d;
    end
  end

  assign vec_o = vec_q;

  p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(vec_q));

endmodule

// File: rtl/tirq_latch.sv
module tirq_latch #(
  parameter int NUM_CH = tirq_pkg::TIRQ_CH_DEFAULT,
  parameter int IDX_W  = tirq_pkg::idx_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic [NUM_CH-1:0] ien_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  vec_o
);

  logic [NUM_CH-1:0] pend_w;
  logic [NUM_CH-1:0] grant_w;
  logic [NUM_CH-1:0] clr_w;
  logic [IDX_W-1:0]  win_idx_w;
  logic              any_w;
  logic              take_w;

  tirq_prio_sel #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_sel (
    .pend_i  (pend_w),
    .any_o   (any_w),
    .idx_o   (win_idx_w),
    .grant_o (grant_w)
  );

  always_comb begin
    take_w = ack_i & any_w;
    clr_w  = take_w ? grant_w : '0;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tirq_pend_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i[g]),
      .en_i   (ien_i[g]),
      .clr_i  (clr_w[g]),
      .pend_o (pend_w[g])
    );
  end

  tirq_vec_reg #(.IDX_W(IDX_W)) u_vec (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (take_w),
    .idx_i  (win_idx_w),
    .vec_o  (vec_o)
  );

  assign irq_o = any_w;

  p_grant_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_w));

  p_one_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !(|(evt_i & ien_i)))
      |=> ($countones(pend_w) == $past($countones(pend_w)) - 1));

  p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o) |=> $stable(vec_o));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (!irq_o && vec_o == '0));

endmodule

// File: tb/tirq_latch_bench.sv
module tirq_latch_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] evt_i;
  logic [2:0] ien_i;
  logic       ack_i;
  logic       irq_o;
  logic [1:0] vec_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tirq_latch u_tirq_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_i),
    .ien_i (ien_i),
    .ack_i (ack_i),
    .irq_o (irq_o),
    .vec_o (vec_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive for one rising edge, then return at the following falling edge.
  task automatic cyc(input logic [2:0] e, input logic a);
    evt_i = e;
    ack_i = a;
    @(posedge clk);
    @(negedge clk);
    evt_i = '0;
    ack_i = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) cyc(3'b000, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    evt_i = '0; ien_i = '0; ack_i = 1'b0;
    @(negedge clk);
    chk("R10 irq in reset", irq_o, 0);
    chk("R10 vec in reset", vec_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_disabled_ignored();
    ien_i = 3'b000;
    cyc(3'b111, 1'b0);
    chk("R3 events with enables low", irq_o, 0);
    ien_i = 3'b101;
    cyc(3'b010, 1'b0);
    chk("R3 event on disabled ch1", irq_o, 0);
  endtask

  task automatic t_set_and_hold();
    ien_i = 3'b100;
    cyc(3'b100, 1'b0);
    chk("R1 irq after ch2 event", irq_o, 1);
    ien_i = 3'b000;
    cyc(3'b000, 1'b0);
    cyc(3'b000, 1'b0);
    chk("R4 pending kept after enable cleared", irq_o, 1);
    cyc(3'b000, 1'b1);
    chk("R6 vec after ack of ch2", vec_o, 2);
    chk("R1 irq after only pending drained", irq_o, 0);
  endtask

  task automatic t_repeat_collapse();
    ien_i = 3'b010;
    cyc(3'b010, 1'b0);
    cyc(3'b010, 1'b0);
    cyc(3'b010, 1'b0);
    chk("R5 irq with repeated ch1 events", irq_o, 1);
    cyc(3'b000, 1'b1);
    chk("R5 vec for ch1", vec_o, 1);
    chk("R5 single ack removes repeated request", irq_o, 0);
  endtask

  task automatic t_priority_drain();
    ien_i = 3'b111;
    cyc(3'b100, 1'b0);
    cyc(3'b001, 1'b0);
    cyc(3'b010, 1'b0);
    cyc(3'b000, 1'b1);
    chk("R2 ch0 first", vec_o, 0);
    chk("R7 others still pending", irq_o, 1);
    cyc(3'b000, 1'b0);
    chk("R6 vec held without ack", vec_o, 0);
    cyc(3'b000, 1'b1);
    chk("R2 ch1 second", vec_o, 1);
    chk("R7 ch2 still pending", irq_o, 1);
    cyc(3'b000, 1'b1);
    chk("R2 ch2 last", vec_o, 2);
    chk("R7 all drained", irq_o, 0);
    cyc(3'b110, 1'b0);
    cyc(3'b000, 1'b1);
    chk("R2 ch1 over ch2", vec_o, 1);
    cyc(3'b000, 1'b1);
    chk("R7 ch2 survived ch1 ack", vec_o, 2);
  endtask

  task automatic t_collision();
    ien_i = 3'b001;
    cyc(3'b001, 1'b0);
    cyc(3'b001, 1'b1);
    chk("R8 vec for colliding ack", vec_o, 0);
    chk("R8 channel stays pending", irq_o, 1);
    cyc(3'b000, 1'b1);
    chk("R8 later ack clears", irq_o, 0);
  endtask

  task automatic t_idle_ack();
    ien_i = 3'b010;
    cyc(3'b010, 1'b0);
    cyc(3'b000, 1'b1);
    chk("R9 setup vec", vec_o, 1);
    cyc(3'b000, 1'b1);
    chk("R9 vec unchanged on idle ack", vec_o, 1);
    chk("R9 irq stays low on idle ack", irq_o, 0);
    ien_i = 3'b100;
    cyc(3'b100, 1'b0);
    chk("R9 new event still latches", irq_o, 1);
    drain();
  endtask

  initial begin
    t_reset();
    t_disabled_ignored();
    t_set_and_hold();
    t_repeat_collapse();
    t_priority_drain();
    t_collision();
    t_idle_ack();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule